// File: doc/BRIEF.md
# Single-Register Command Slave with Start Strobe

This block is a memory-mapped slave with a 32-bit data path. It holds one three-bit command register and drives a one-cycle start strobe toward a downstream engine each time that register is written. The narrowest legal address port is one bit wide, so the slave occupies two word locations. Only one of them is real. The other location is padding.

Interconnects between a host and this slave can split or duplicate a single host access. A width adapter may break a 32-bit access into narrow cycles that each enable only some byte lanes. A wider upstream bus may issue two 32-bit cycles for one host access. A write therefore counts only when it targets the real location and enables the least significant byte lane. Any other write leaves the register untouched and raises no strobe.

Reads return the command bits in the low positions of the read data, with zeros above them. The read latency is fixed at one cycle, and the slave never inserts wait states.

Top module: `cmd_slave`

## Requirements
- R1: While rst_n is low, cmd_o, start_o and bus_rdata are all zero.
- R2: A write with bus_addr equal to 0 and bus_be bit 0 set is accepted. It stores bus_wdata bits [2:0] into the command register, visible on cmd_o after the sampling edge. Bits [31:3] of the write data are ignored.
- R3: An accepted write raises start_o for exactly one clock cycle, starting at the edge that samples the write.
- R4: Accepted writes on consecutive cycles produce start pulses on consecutive cycles, and cmd_o follows each written value.
- R5: A write with bus_addr equal to 1 (the padding location) leaves cmd_o unchanged and keeps start_o low.
- R6: A write with bus_be bit 0 clear is ignored, whatever the other lanes hold. It leaves cmd_o unchanged and keeps start_o low.
- R7: When bus_read is sampled high, bus_rdata shows {29'b0, command register} after that edge, for either address. When bus_read is low, bus_rdata holds its last value.
- R8: A read never changes the command register and never raises start_o.
- R9: A read and an accepted write sampled at the same edge return the register value from before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr | input | 1 | Word address: 0 is the register, 1 is padding |
| bus_write | input | 1 | Write request |
| bus_read | input | 1 | Read request |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte-lane enables |
| bus_rdata | output | 32 | Registered read data, valid one cycle after bus_read |
| cmd_o | output | 3 | Stored command bits for the engine |
| start_o | output | 1 | One-cycle start strobe for the engine |

## Verification
The bench targets the duplicated and split cycles an interconnect can produce:
- A write to the padding location, which a decoder that ignores the address would accept and use to fire a second strobe.
- A write with only the upper lanes enabled, which a design that ignores the byte enables would wrongly store.

It also checks pulse width under back-to-back writes, where a level-based or edge-detected strobe would merge two pulses into one. Finally, it checks a read that coincides with a write, which exposes read data taken after the update instead of before it.

// File: rtl/cmd_slave_pkg.sv
package cmd_slave_pkg;
  localparam int unsigned CMD_BITS = 3;
  typedef logic [CMD_BITS-1:0] cmd_t;
endpackage

// File: rtl/cmd_decode.sv
module cmd_decode #(
  parameter int unsigned ADDR_W = 1,
  parameter int unsigned BE_W   = 4
) (
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BE_W-1:0]   bus_be,
  output logic              wr_accept
);
  // Only the real word, with the low lane enabled, counts as a write.
  always_comb begin
    wr_accept = bus_write && (bus_addr == '0) && bus_be[0];
  end
endmodule

// File: rtl/cmd_store.sv
module cmd_store
  import cmd_slave_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_accept,
  input  cmd_t wr_cmd,
  output cmd_t cmd_q,
  output logic start_q
);
  cmd_t cmd_d;
  logic start_d;

  always_comb begin
    cmd_d   = cmd_q;
    start_d = wr_accept;
    if (wr_accept) cmd_d = wr_cmd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      start_q <= 1'b0;
    end else begin
      cmd_q   <= cmd_d;
      start_q <= start_d;
    end
  end

  // R3
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q && !wr_accept) |=> !start_q);
endmodule

// File: rtl/cmd_readback.sv
module cmd_readback
  import cmd_slave_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  cmd_t              cmd_q,
  output logic [DATA_W-1:0] rdata_q
);
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    rdata_d = rdata_q;
    if (rd_en) begin
      rdata_d = '0;
      rdata_d[CMD_BITS-1:0] = cmd_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  // R7
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata_q));
endmodule

// File: rtl/cmd_slave.sv
module cmd_slave
  import cmd_slave_pkg::*;
#(
  parameter int unsigned ADDR_W = 1,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_write,
  input  logic              bus_read,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [BE_W-1:0]   bus_be,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [CMD_BITS-1:0] cmd_o,
  output logic              start_o
);
  logic wr_accept;
  cmd_t cmd_q;

  cmd_decode #(.ADDR_W(ADDR_W), .BE_W(BE_W)) dec_i (
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .wr_accept (wr_accept)
  );

  cmd_store store_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_accept (wr_accept),
    .wr_cmd    (bus_wdata[CMD_BITS-1:0]),
    .cmd_q     (cmd_q),
    .start_q   (start_o)
  );

  cmd_readback #(.DATA_W(DATA_W)) rb_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (bus_read),
    .cmd_q   (cmd_q),
    .rdata_q (bus_rdata)
  );

  assign cmd_o = cmd_q;

  // R2
  store_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_write && bus_addr == '0 && bus_be[0]) |=> cmd_o == $past(bus_wdata[CMD_BITS-1:0]));
  // R5
  pad_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_write && bus_addr != '0) |=> ($stable(cmd_o) && !start_o));
  // R6
  lane0_required_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_write && !bus_be[0]) |=> ($stable(cmd_o) && !start_o));
  // R8
  read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_read && !bus_write) |=> ($stable(cmd_o) && !start_o));
  // R7
  rdata_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_read |=> bus_rdata[DATA_W-1:CMD_BITS] == '0);
endmodule

// File: tb/cmd_slave_tb_top.sv
`timescale 1ns/1ps
module cmd_slave_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [0:0]  bus_addr;
  logic        bus_write, bus_read;
  logic [31:0] bus_wdata;
  logic [3:0]  bus_be;
  logic [31:0] bus_rdata;
  logic [2:0]  cmd_o;
  logic        start_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cmd_slave dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_write(bus_write),
    .bus_read(bus_read), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .bus_rdata(bus_rdata), .cmd_o(cmd_o), .start_o(start_o)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle();
    bus_write = 1'b0; bus_read = 1'b0; bus_addr = '0;
    bus_wdata = '0; bus_be = '0;
  endtask

  // Drive one cycle at negedge; returns at the following negedge.
  task automatic cycle(input logic w, input logic r, input logic a,
                       input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_write = w; bus_read = r; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    bus_write = 1'b1; bus_read = 1'b1; bus_addr = '0;
    bus_wdata = 32'hFFFF_FFFF; bus_be = 4'hF;
    repeat (3) @(negedge clk);
    check("R1 cmd", {29'b0, cmd_o}, 32'h0);
    check("R1 start", {31'b0, start_o}, 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);
    idle();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_write_pulse();
    cycle(1, 0, 0, 32'hABCD_EF05, 4'hF);
    check("R2 cmd low bits", {29'b0, cmd_o}, 32'h5);
    check("R3 start high", {31'b0, start_o}, 32'h1);
    @(negedge clk);
    check("R3 start one cycle", {31'b0, start_o}, 32'h0);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    bus_write = 1; bus_addr = 0; bus_be = 4'h1; bus_wdata = 32'h2;
    @(negedge clk);
    check("R4 first start", {31'b0, start_o}, 32'h1);
    check("R4 first cmd", {29'b0, cmd_o}, 32'h2);
    bus_wdata = 32'h7;
    @(negedge clk);
    idle();
    check("R4 second start", {31'b0, start_o}, 32'h1);
    check("R4 second cmd", {29'b0, cmd_o}, 32'h7);
    @(negedge clk);
    check("R4 start drops", {31'b0, start_o}, 32'h0);
  endtask

  task automatic t_pad_write();
    cycle(1, 0, 1, 32'h0000_0003, 4'hF);
    check("R5 pad cmd", {29'b0, cmd_o}, 32'h7);
    check("R5 pad start", {31'b0, start_o}, 32'h0);
  endtask

  task automatic t_upper_lanes();
    cycle(1, 0, 0, 32'h0000_0001, 4'hE);
    check("R6 lane cmd", {29'b0, cmd_o}, 32'h7);
    check("R6 lane start", {31'b0, start_o}, 32'h0);
  endtask

  task automatic t_read();
    cycle(1, 0, 0, 32'hFFFF_FFF3, 4'h1);
    cycle(0, 1, 0, 32'h0, 4'h0);
    check("R7 rdata", bus_rdata, 32'h3);
    check("R8 read start", {31'b0, start_o}, 32'h0);
    check("R8 read cmd", {29'b0, cmd_o}, 32'h3);
    cycle(0, 1, 1, 32'h0, 4'h0);
    check("R7 rdata pad addr", bus_rdata, 32'h3);
    cycle(1, 0, 0, 32'h6, 4'hF);
    check("R7 rdata holds", bus_rdata, 32'h3);
  endtask

  task automatic t_read_write();
    cycle(1, 1, 0, 32'h1, 4'hF);
    check("R9 old value read", bus_rdata, 32'h6);
    check("R9 new cmd", {29'b0, cmd_o}, 32'h1);
    check("R9 start", {31'b0, start_o}, 32'h1);
  endtask

  initial begin
    t_reset();
    t_write_pulse();
    t_back_to_back();
    t_pad_write();
    t_upper_lanes();
    t_read();
    t_read_write();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule